// File: doc/BRIEF.md
# Dual-Clock Serial Field Memory

This block is a sequential-access store for one video line or field. Words enter at the write port in strict address order and leave at the read port in the same order. Each port has its own clock and its own address pointer, so a field can be written at one rate and read back at another with a fixed delay between the two. There are no full or empty flags and no arbitration between the ports. The system that uses the block keeps the read side behind the write side by controlling when each pointer is cleared.

Each port has an active-low enable that gates its clock, and an active-low pointer clear that is sampled on that port's rising clock edge. Each pointer wraps from the last location back to the first without help. The read port registers the word it fetches and has an output-enable flag. This flag drops for every read edge taken with the enable high, and it rises again on the next enabled edge. The port has no valid/ready handshake: the active-low enable marks a word as valid, and the block can never stall either port. Each port also has a sticky flag. It reports a run between two pointer clears that was shorter than the minimum the storage needs.

Top module: `fieldmem_serial`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_n` low, `wr_data` is stored at the location the write pointer selects, and the write pointer advances by one.
- R2: On a rising `rd_clk` edge with `rd_en_n` low, the word at the read-pointer location appears on `rd_data` after that edge, `rd_data_oe` goes high, and the read pointer advances by one.
- R3: A pointer clear (`wr_ptr_clr_n` or `rd_ptr_clr_n` low at that port's rising edge) selects location 0 for that edge. If the same edge is enabled, the access uses location 0 and the pointer then holds 1. Otherwise the pointer holds 0.
- R4: An enabled access at location DEPTH-1 (default 5048 words, locations 0 to 5047) moves the pointer to location 0 with no clear needed.
- R5: A `wr_clk` edge with `wr_en_n` high stores nothing and leaves the write pointer unchanged.
- R6: A `rd_clk` edge with `rd_en_n` high leaves the read pointer and `rd_data` unchanged, and drives `rd_data_oe` low after that edge.
- R7: Words are DATA_W bits wide (default 8) on both ports.
- R8: Each port has a run count: the number of enabled edges since that port's previous clear, including the clear edge itself when it was enabled. A clear that arrives while this count is below MIN_RUN (default 18) sets that port's short-run flag (`wr_short_run` or `rd_short_run`). The first clear after reset never sets the flag. Once set, the flag stays high until that port's asynchronous reset.
- R9: While a port's asynchronous reset is low, its pointer and run count are 0 and its short-run flag is low. The read reset also drives `rd_data` to 0 and `rd_data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_arst_n | input | 1 | Asynchronous reset for the write port, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_ptr_clr_n | input | 1 | Write pointer clear, active low, sampled on `wr_clk` |
| wr_data | input | DATA_W | Word to store |
| wr_short_run | output | 1 | Sticky flag: a write run was shorter than the minimum |
| rd_clk | input | 1 | Read-port clock |
| rd_arst_n | input | 1 | Asynchronous reset for the read port, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_ptr_clr_n | input | 1 | Read pointer clear, active low, sampled on `rd_clk` |
| rd_data | output | DATA_W | Registered read word |
| rd_data_oe | output | 1 | High when `rd_data` would be driven, low when it would be high impedance |
| rd_short_run | output | 1 | Sticky flag: a read run was shorter than the minimum |

## Verification
The bench builds the block with DEPTH set to 40 and keeps DATA_W at 8 and MIN_RUN at 18. The small depth means that full passes and wraps on both pointers happen many times in a short run. The minimum run stays at its real value, so the short-run check is tested exactly at its limit: a run of 18 enabled edges, then a run of 17. The write and read clocks have different periods, which exercises each port's pointer on its own clock.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum int unsigned {
    FM_PORT_WR = 0,
    FM_PORT_RD = 1
  } fm_port_e;

  localparam int unsigned FM_NUM_PORTS = 2;
endpackage

// File: rtl/fm_ptr.sv
module fm_ptr #(
  parameter int unsigned DEPTH = 5048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en_n,
  input  logic          clr_n,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ptr_q,
  output logic          fire
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // address used by this edge: a clear overrides the stored pointer
  always_comb begin
    addr = clr_n ? ptr_q : '0;
    fire = ~en_n;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ptr_q <= '0;
    end else if (fire) begin
      ptr_q <= (addr == LAST) ? '0 : addr + 1'b1;
    end else begin
      ptr_q <= addr;
    end
  end
endmodule

// File: rtl/fm_run_mon.sv
module fm_run_mon #(
  parameter int unsigned MIN_RUN = 18,
  parameter int unsigned CW      = $clog2(MIN_RUN + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_n,
  input  logic fire,
  output logic short_run
);
  localparam logic [CW-1:0] RUN_SAT = CW'(MIN_RUN);

  logic [CW-1:0] run_cnt;
  logic          armed;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_cnt   <= '0;
      armed     <= 1'b0;
      short_run <= 1'b0;
    end else if (!clr_n) begin
      if (armed && (run_cnt < RUN_SAT)) short_run <= 1'b1;
      armed   <= 1'b1;
      run_cnt <= CW'(fire);
    end else if (fire && (run_cnt != RUN_SAT)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fm_store.sv
module fm_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5048,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              wfire,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rarst_n,
  input  logic              rfire,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata_q,
  output logic              oe_q
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (wfire) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rarst_n) begin
    if (!rarst_n) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= rfire;
      if (rfire) rdata_q <= cells[raddr];
    end
  end
endmodule

// File: rtl/fieldmem_serial.sv
module fieldmem_serial #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 5048,
  parameter int unsigned MIN_RUN = 18,
  parameter int unsigned AW      = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_arst_n,
  input  logic              wr_en_n,
  input  logic              wr_ptr_clr_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_short_run,
  input  logic              rd_clk,
  input  logic              rd_arst_n,
  input  logic              rd_en_n,
  input  logic              rd_ptr_clr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_oe,
  output logic              rd_short_run
);
  import fm_pkg::*;

  localparam int unsigned NP = FM_NUM_PORTS;

  logic [NP-1:0] p_clk, p_arst_n, p_en_n, p_clr_n, p_fire, p_short;
  logic [AW-1:0] p_addr [NP];
  logic [AW-1:0] p_ptr  [NP];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  always_comb begin
    p_clk[FM_PORT_WR]    = wr_clk;
    p_clk[FM_PORT_RD]    = rd_clk;
    p_arst_n[FM_PORT_WR] = wr_arst_n;
    p_arst_n[FM_PORT_RD] = rd_arst_n;
    p_en_n[FM_PORT_WR]   = wr_en_n;
    p_en_n[FM_PORT_RD]   = rd_en_n;
    p_clr_n[FM_PORT_WR]  = wr_ptr_clr_n;
    p_clr_n[FM_PORT_RD]  = rd_ptr_clr_n;
    wr_ptr_q             = p_ptr[FM_PORT_WR];
    rd_ptr_q             = p_ptr[FM_PORT_RD];
    wr_short_run         = p_short[FM_PORT_WR];
    rd_short_run         = p_short[FM_PORT_RD];
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    fm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk   (p_clk[p]),
      .arst_n(p_arst_n[p]),
      .en_n  (p_en_n[p]),
      .clr_n (p_clr_n[p]),
      .addr  (p_addr[p]),
      .ptr_q (p_ptr[p]),
      .fire  (p_fire[p])
    );

    fm_run_mon #(.MIN_RUN(MIN_RUN)) u_run (
      .clk      (p_clk[p]),
      .arst_n   (p_arst_n[p]),
      .clr_n    (p_clr_n[p]),
      .fire     (p_fire[p]),
      .short_run(p_short[p])
    );
  end

  fm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .wclk   (wr_clk),
    .wfire  (p_fire[FM_PORT_WR]),
    .waddr  (p_addr[FM_PORT_WR]),
    .wdata  (wr_data),
    .rclk   (rd_clk),
    .rarst_n(rd_arst_n),
    .rfire  (p_fire[FM_PORT_RD]),
    .raddr  (p_addr[FM_PORT_RD]),
    .rdata_q(rd_data),
    .oe_q   (rd_data_oe)
  );
endmodule

// File: rtl/fieldmem_serial_chk.sv
module fieldmem_serial_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5048,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input logic              wr_clk,
  input logic              wr_arst_n,
  input logic              wr_en_n,
  input logic              wr_ptr_clr_n,
  input logic              wr_short_run,
  input logic [AW-1:0]     wr_ptr_q,
  input logic              rd_clk,
  input logic              rd_arst_n,
  input logic              rd_en_n,
  input logic              rd_ptr_clr_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_data_oe,
  input logic              rd_short_run,
  input logic [AW-1:0]     rd_ptr_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  assert_wr_advance_R1: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (!wr_en_n && wr_ptr_clr_n && wr_ptr_q != LAST) |=> wr_ptr_q == $past(wr_ptr_q) + ONE);

  assert_rd_advance_R2: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (!rd_en_n && rd_ptr_clr_n && rd_ptr_q != LAST) |=> rd_ptr_q == $past(rd_ptr_q) + ONE);

  assert_rd_oe_on_R2: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    !rd_en_n |=> rd_data_oe);

  assert_wr_clear_R3: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (!wr_ptr_clr_n && !wr_en_n) |=> wr_ptr_q == ONE);

  assert_rd_clear_idle_R3: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (!rd_ptr_clr_n && rd_en_n) |=> rd_ptr_q == '0);

  assert_wr_wrap_R4: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (!wr_en_n && wr_ptr_clr_n && wr_ptr_q == LAST) |=> wr_ptr_q == '0);

  assert_rd_wrap_R4: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (!rd_en_n && rd_ptr_clr_n && rd_ptr_q == LAST) |=> rd_ptr_q == '0);

  assert_wr_hold_R5: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (wr_en_n && wr_ptr_clr_n) |=> $stable(wr_ptr_q));

  assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (rd_en_n && rd_ptr_clr_n) |=> ($stable(rd_ptr_q) && $stable(rd_data) && !rd_data_oe));

  assert_wr_sticky_R8: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    wr_short_run |=> wr_short_run);

  assert_rd_sticky_R8: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    rd_short_run |=> rd_short_run);
endmodule

bind fieldmem_serial fieldmem_serial_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/tb_fieldmem_serial.sv
module tb_fieldmem_serial;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DW         = 8;
  localparam int DEPTH      = 40;
  localparam int MIN_RUN    = 18;
  localparam int WATCHDOG   = 150000;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_arst_n, rd_arst_n;
  logic          wr_en_n = 1'b1, wr_ptr_clr_n = 1'b1;
  logic          rd_en_n = 1'b1, rd_ptr_clr_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_data_oe, wr_short_run, rd_short_run;

  fieldmem_serial #(.DATA_W(DW), .DEPTH(DEPTH), .MIN_RUN(MIN_RUN)) dut (.*);

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

  int total = 0, bad = 0;

  // reference model state, index 0 = write port, 1 = read port
  logic [DW-1:0] m_mem [DEPTH];
  int            m_ptr [2];
  int            m_cnt [2];
  bit            m_arm [2];
  bit            m_flag[2];
  logic [DW-1:0] m_rdata;
  bit            m_oe;

  function automatic int nxt(int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  function automatic int sat_inc(int c);
    return (c >= MIN_RUN) ? MIN_RUN : c + 1;
  endfunction

  task automatic model_step(int p, bit en, bit clr, output int addr);
    addr = clr ? 0 : m_ptr[p];
    if (clr) begin
      if (m_arm[p] && m_cnt[p] < MIN_RUN) m_flag[p] = 1'b1;
      m_arm[p] = 1'b1;
      m_cnt[p] = en ? 1 : 0;
    end else if (en) begin
      m_cnt[p] = sat_inc(m_cnt[p]);
    end
    m_ptr[p] = en ? nxt(addr) : addr;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(bit en, bit clr, logic [DW-1:0] d);
    int a;
    @(negedge wr_clk);
    wr_en_n = ~en; wr_ptr_clr_n = ~clr; wr_data = d;
    @(posedge wr_clk);
    model_step(0, en, clr, a);
    if (en) m_mem[a] = d;
    #1;
    wr_en_n = 1'b1; wr_ptr_clr_n = 1'b1;
    check("R8 wr_short_run", {31'd0, wr_short_run}, {31'd0, m_flag[0]});
  endtask

  task automatic do_rd(bit en, bit clr, string tag);
    int a;
    @(negedge rd_clk);
    rd_en_n = ~en; rd_ptr_clr_n = ~clr;
    @(posedge rd_clk);
    model_step(1, en, clr, a);
    if (en) m_rdata = m_mem[a];
    m_oe = en;
    #1;
    rd_en_n = 1'b1; rd_ptr_clr_n = 1'b1;
    check(tag, {24'd0, rd_data}, {24'd0, m_rdata});
    check("R2/R6 rd_data_oe", {31'd0, rd_data_oe}, {31'd0, m_oe});
    check("R8 rd_short_run", {31'd0, rd_short_run}, {31'd0, m_flag[1]});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge wr_clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      m_ptr[p] = 0; m_cnt[p] = 0; m_arm[p] = 1'b0; m_flag[p] = 1'b0;
    end
    m_rdata = '0; m_oe = 1'b0;

    wr_arst_n = 1'b0; rd_arst_n = 1'b0;
    #(3 * RD_PERIOD);
    // R9: reset state
    check("R9 rd_data", {24'd0, rd_data}, 32'd0);
    check("R9 rd_data_oe", {31'd0, rd_data_oe}, 32'd0);
    check("R9 wr_short_run", {31'd0, wr_short_run}, 32'd0);
    check("R9 rd_short_run", {31'd0, rd_short_run}, 32'd0);
    @(negedge wr_clk) wr_arst_n = 1'b1;
    @(negedge rd_clk) rd_arst_n = 1'b1;

    // R1 R3 R4 R7: clear then fill past one wrap
    do_wr(1'b1, 1'b1, 8'hC0);
    for (int i = 1; i < DEPTH + 5; i++) do_wr(1'b1, 1'b0, DW'(i * 7 + 3));
    // R5: disabled write edges store nothing
    for (int i = 0; i < 4; i++) do_wr(1'b0, 1'b0, 8'hA5);
    do_wr(1'b1, 1'b0, 8'h3C);

    // R2 R3 R4: clear read, read past one wrap
    do_rd(1'b1, 1'b1, "R3 rd first word after clear");
    for (int i = 1; i < DEPTH + 3; i++) do_rd(1'b1, 1'b0, "R4 R1 R5 R7 rd_data");
    // R6: idle read edges hold pointer and data
    for (int i = 0; i < 3; i++) do_rd(1'b0, 1'b0, "R6 rd_data held");
    do_rd(1'b1, 1'b0, "R6 pointer unchanged");

    // R8 boundary on the write port: a run of 18 passes, 17 flags
    do_wr(1'b1, 1'b1, 8'h11);
    for (int i = 1; i < MIN_RUN; i++) do_wr(1'b1, 1'b0, DW'(i));
    do_wr(1'b0, 1'b1, 8'h00);
    check("R8 wr run of 18 no flag", {31'd0, wr_short_run}, 32'd0);
    for (int i = 0; i < MIN_RUN - 1; i++) do_wr(1'b1, 1'b0, DW'(i + 50));
    do_wr(1'b0, 1'b1, 8'h00);
    check("R8 wr run of 17 flags", {31'd0, wr_short_run}, 32'd1);

    // R8 boundary on the read port
    do_rd(1'b1, 1'b1, "R3 rd after clear");
    for (int i = 1; i < MIN_RUN; i++) do_rd(1'b1, 1'b0, "R2 rd_data");
    do_rd(1'b0, 1'b1, "R6 rd idle clear");
    check("R8 rd run of 18 no flag", {31'd0, rd_short_run}, 32'd0);
    for (int i = 0; i < MIN_RUN - 1; i++) do_rd(1'b1, 1'b0, "R2 rd_data");
    do_rd(1'b0, 1'b1, "R6 rd idle clear");
    check("R8 rd run of 17 flags", {31'd0, rd_short_run}, 32'd1);

    // random phases: write bursts then read bursts
    for (int it = 0; it < 150; it++) begin
      int n;
      n = 1 + int'($urandom % 12);
      for (int k = 0; k < n; k++)
        do_wr(($urandom % 10) < 7, ($urandom % 25) == 0, DW'($urandom));
      n = 1 + int'($urandom % 12);
      for (int k = 0; k < n; k++)
        do_rd(($urandom % 10) < 7, ($urandom % 25) == 0, "R1 R2 R3 R4 random rd_data");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule